// File: doc/BRIEF.md
# Footprint-Aware Page Walker for a Tagless DRAM Cache

This block is the walker that a TLB calls on a miss, or when a segment of an already cached page is found invalid. It looks up one extended page table entry, takes that entry's lock bit through an atomic test-and-set on a simple request/response memory port, and decides how to fill the TLB. A non-cacheable page is passed back with its physical address and a bypass flag. A page that already has a DRAM-cache block (nonzero valid vector) is returned from the stored cache address, and the demanded segment is fetched if it is missing. A page with an all-zero valid vector gets a new block from an allocator. The walker then copies in only the segments its reference vector remembers, plus the demanded one.

Segment transfers go out one at a time, in ascending index order, to a fill engine. Every walk ends with a single entry write-back that clears the lock and carries the updated vectors and address. The TLB fill is issued only after that write has been acknowledged. The page table is modelled as a single level, indexed directly by the virtual page number.

Top module: `footprintWalker`

## Requirements
- R1: Entry layout, with S = SEGS: bits [S-1:0] valid vector, [2S-1:S] reference vector, bit 2S cached flag, bit 2S+1 non-cacheable flag, bit 2S+2 lock flag, upper bits address. A walk starts with a test-and-set request (kind 1) at address = page number, and the response returns the previous entry.
- R2: If the returned lock flag is set, the walker changes nothing and issues the next test-and-set exactly BACKOFF+1 cycles after the response cycle.
- R3: A non-cacheable entry produces a TLB fill with the entry address, bypass = 1 and both vectors zero. It makes no allocation and no segment transfer.
- R4: A nonzero valid vector whose demanded bit is set produces a TLB fill with the stored address and vectors, and no transfer.
- R5: A nonzero valid vector whose demanded bit is clear produces one transfer of the demanded segment to the stored cache address. The demanded bit is then set in both the valid and reference vectors, in the TLB fill and in the entry.
- R6: An all-zero valid vector produces one allocation request carrying the entry address and the page number. The granted cache address replaces the entry address, and the cached flag is set.
- R7: After an allocation, the transferred segments are the reference vector OR the demanded bit, so a zero reference vector fetches only the demanded segment. Valid and reference vectors both end equal to that mask.
- R8: Segment transfers are issued in ascending index order, with at most one outstanding.
- R9: Every walk ends with exactly one entry write (kind 2) with the lock flag clear, and the TLB fill follows that write's acknowledgement.
- R10: walkReady is low from acceptance until the cycle after the TLB fill. A request held during that time is accepted afterwards.
- R11: After reset, walkReady is 1 and all request and fill strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkReq | input | 1 | Walk request |
| walkVpn | input | VPN_W | Page number to walk |
| walkSeg | input | SEG_IW | Demanded segment index |
| walkReady | output | 1 | Walker idle, request accepted |
| memReqValid | output | 1 | Memory request strobe |
| memReqKind | output | 2 | 1 test-and-set, 2 write |
| memReqAddr | output | VPN_W | Entry address |
| memReqData | output | PTE_W | Entry write data |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | PTE_W | Previous entry contents |
| allocReq | output | 1 | Block allocation request |
| allocPhys | output | ADDR_W | Physical address recorded for the block |
| allocVpn | output | VPN_W | Page number recorded for the block |
| allocDone | input | 1 | Allocation granted |
| allocAddr | input | ADDR_W | Granted cache address |
| fillReq | output | 1 | Segment transfer request |
| fillAddr | output | ADDR_W | Cache block address |
| fillSeg | output | SEG_IW | Segment to transfer |
| fillDone | input | 1 | Segment transfer complete |
| tlbFillValid | output | 1 | TLB fill strobe |
| tlbFillVpn | output | VPN_W | Page number of the fill |
| tlbFillAddr | output | ADDR_W | Cache or physical address |
| tlbFillValidVec | output | SEGS | Valid vector |
| tlbFillRefVec | output | SEGS | Reference vector |
| tlbFillBypass | output | 1 | Access bypasses the DRAM cache |

## Verification
Two walks meet in one cycle: the walker retiring one walk with its TLB fill pulse while the next walk request is already asserted and waiting. The bench provokes this by holding a second request, for a different page, high during an allocating walk. It then judges that walkReady stayed low while it waited, and that both fills, both transfer sequences and both entry write-backs come out in order and with correct values. A lock collision is also provoked: the first test-and-set answers with the lock held, and the bench times the retry gap.

// File: rtl/walkerPkg.sv
package walkerPkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOCK, ST_LOCKWAIT, ST_BACKOFF, ST_DECIDE, ST_ALLOC,
    ST_ALLOCWAIT, ST_FILL, ST_FILLWAIT, ST_WRITE, ST_WRWAIT, ST_RESPOND
  } walkState_t;

  typedef struct packed {
    logic capReq;
    logic capPte;
    logic loadBackoff;
    logic tickBackoff;
    logic loadDemand;
    logic takeAlloc;
    logic retireSeg;
  } walkStrobes_t;

  localparam logic [1:0] MEM_TAS   = 2'd1;
  localparam logic [1:0] MEM_WRITE = 2'd2;
endpackage

// File: rtl/walkerData.sv
module walkerData
  import walkerPkg::*;
#(
  parameter int SEGS    = 8,
  parameter int SEG_IW  = 3,
  parameter int ADDR_W  = 20,
  parameter int VPN_W   = 8,
  parameter int PTE_W   = 39,
  parameter int BACKOFF = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       strobes,
  input  logic [VPN_W-1:0]   walkVpn,
  input  logic [SEG_IW-1:0]  walkSeg,
  input  logic [PTE_W-1:0]   memRspData,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic               fillReqIn,
  input  logic               tlbFillValidIn,
  input  logic               memWriteIn,
  output logic               rspLocked,
  output logic               pteNc,
  output logic               validNz,
  output logic               demandHit,
  output logic               pendEmpty,
  output logic               backoffZero,
  output logic [VPN_W-1:0]   memReqAddr,
  output logic [PTE_W-1:0]   memReqData,
  output logic [ADDR_W-1:0]  allocPhys,
  output logic [VPN_W-1:0]   allocVpn,
  output logic [ADDR_W-1:0]  fillAddr,
  output logic [SEG_IW-1:0]  fillSeg,
  output logic [VPN_W-1:0]   tlbFillVpn,
  output logic [ADDR_W-1:0]  tlbFillAddr,
  output logic [SEGS-1:0]    tlbFillValidVec,
  output logic [SEGS-1:0]    tlbFillRefVec,
  output logic               tlbFillBypass
);
  localparam int REF_LO  = SEGS;
  localparam int CACHE_B = 2 * SEGS;
  localparam int NC_B    = 2 * SEGS + 1;
  localparam int LOCK_B  = 2 * SEGS + 2;
  localparam int ADDR_LO = 2 * SEGS + 3;
  localparam int BK_W    = $clog2(BACKOFF + 1);
  localparam logic [BK_W-1:0] BK_INIT = BK_W'(BACKOFF - 1);

  logic [VPN_W-1:0]  vpnQ;
  logic [SEG_IW-1:0] segQ;
  logic [SEGS-1:0]   validQ, refQ, pendQ;
  logic [ADDR_W-1:0] addrQ;
  logic              cachedQ, ncQ;
  logic [BK_W-1:0]   bkCnt;
  logic [SEGS-1:0]   demandBit, curBit;
  logic [SEG_IW-1:0] curSeg;

  always_comb begin
    demandBit       = '0;
    demandBit[segQ] = 1'b1;
  end

  // lowest pending segment wins: ascending transfer order
  always_comb begin
    curSeg = '0;
    curBit = '0;
    for (int i = SEGS - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        curSeg    = SEG_IW'(i);
        curBit    = '0;
        curBit[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ    <= '0;
      segQ    <= '0;
      validQ  <= '0;
      refQ    <= '0;
      pendQ   <= '0;
      addrQ   <= '0;
      cachedQ <= 1'b0;
      ncQ     <= 1'b0;
      bkCnt   <= '0;
    end else begin
      if (strobes.capReq) begin
        vpnQ <= walkVpn;
        segQ <= walkSeg;
      end
      if (strobes.capPte) begin
        validQ  <= memRspData[SEGS-1:0];
        refQ    <= memRspData[2*SEGS-1:REF_LO];
        cachedQ <= memRspData[CACHE_B];
        ncQ     <= memRspData[NC_B];
        addrQ   <= memRspData[PTE_W-1:ADDR_LO];
        pendQ   <= '0;
      end
      if (strobes.loadBackoff) begin
        bkCnt <= BK_INIT;
      end else if (strobes.tickBackoff && bkCnt != '0) begin
        bkCnt <= bkCnt - 1'b1;
      end
      if (strobes.loadDemand) begin
        pendQ <= demandBit;
        refQ  <= refQ | demandBit;
      end
      if (strobes.takeAlloc) begin
        addrQ   <= allocAddr;
        cachedQ <= 1'b1;
        pendQ   <= refQ | demandBit;
        refQ    <= refQ | demandBit;
      end
      if (strobes.retireSeg) begin
        validQ <= validQ | curBit;
        pendQ  <= pendQ & ~curBit;
      end
    end
  end

  assign rspLocked   = memRspData[LOCK_B];
  assign pteNc       = ncQ;
  assign validNz     = |validQ;
  assign demandHit   = validQ[segQ];
  assign pendEmpty   = (pendQ == '0);
  assign backoffZero = (bkCnt == '0);

  assign memReqAddr      = vpnQ;
  assign memReqData      = {addrQ, 1'b0, ncQ, cachedQ, refQ, validQ};
  assign allocPhys       = addrQ;
  assign allocVpn        = vpnQ;
  assign fillAddr        = addrQ;
  assign fillSeg         = curSeg;
  assign tlbFillVpn      = vpnQ;
  assign tlbFillAddr     = addrQ;
  assign tlbFillValidVec = ncQ ? '0 : validQ;
  assign tlbFillRefVec   = ncQ ? '0 : refQ;
  assign tlbFillBypass   = ncQ;

  // order tracking for the transfer-order assertion
  logic [SEG_IW-1:0] lastFillSeg;
  logic              haveFill;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastFillSeg <= '0;
      haveFill    <= 1'b0;
    end else if (strobes.capReq) begin
      haveFill <= 1'b0;
    end else if (fillReqIn) begin
      haveFill    <= 1'b1;
      lastFillSeg <= fillSeg;
    end
  end

  assert_fill_ascending_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillReqIn && haveFill) |-> (fillSeg > lastFillSeg));
  assert_write_unlocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWriteIn |-> !memReqData[LOCK_B]);
  assert_bypass_vectors_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tlbFillValidIn && tlbFillBypass) |-> (tlbFillValidVec == '0 && tlbFillRefVec == '0));
  assert_demand_present_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tlbFillValidIn && !tlbFillBypass) |-> tlbFillValidVec[segQ]);
endmodule

// File: rtl/walkerCtrl.sv
module walkerCtrl
  import walkerPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         walkReq,
  input  logic         memRspValid,
  input  logic         allocDone,
  input  logic         fillDone,
  input  logic         rspLocked,
  input  logic         pteNc,
  input  logic         validNz,
  input  logic         demandHit,
  input  logic         pendEmpty,
  input  logic         backoffZero,
  output walkStrobes_t strobes,
  output logic         walkReady,
  output logic         memReqValid,
  output logic [1:0]   memReqKind,
  output logic         allocReq,
  output logic         fillReq,
  output logic         tlbFillValid
);
  walkState_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt          = st;
    strobes      = '0;
    walkReady    = 1'b0;
    memReqValid  = 1'b0;
    memReqKind   = 2'd0;
    allocReq     = 1'b0;
    fillReq      = 1'b0;
    tlbFillValid = 1'b0;
    case (st)
      ST_IDLE: begin
        walkReady = 1'b1;
        if (walkReq) begin
          strobes.capReq = 1'b1;
          nxt = ST_LOCK;
        end
      end
      ST_LOCK: begin
        memReqValid = 1'b1;
        memReqKind  = MEM_TAS;
        nxt = ST_LOCKWAIT;
      end
      ST_LOCKWAIT: begin
        if (memRspValid) begin
          if (rspLocked) begin
            strobes.loadBackoff = 1'b1;
            nxt = ST_BACKOFF;
          end else begin
            strobes.capPte = 1'b1;
            nxt = ST_DECIDE;
          end
        end
      end
      ST_BACKOFF: begin
        strobes.tickBackoff = 1'b1;
        if (backoffZero) nxt = ST_LOCK;
      end
      ST_DECIDE: begin
        if (pteNc) begin
          nxt = ST_WRITE;
        end else if (validNz) begin
          if (demandHit) begin
            nxt = ST_WRITE;
          end else begin
            strobes.loadDemand = 1'b1;
            nxt = ST_FILL;
          end
        end else begin
          nxt = ST_ALLOC;
        end
      end
      ST_ALLOC: begin
        allocReq = 1'b1;
        nxt = ST_ALLOCWAIT;
      end
      ST_ALLOCWAIT: begin
        if (allocDone) begin
          strobes.takeAlloc = 1'b1;
          nxt = ST_FILL;
        end
      end
      ST_FILL: begin
        if (pendEmpty) begin
          nxt = ST_WRITE;
        end else begin
          fillReq = 1'b1;
          nxt = ST_FILLWAIT;
        end
      end
      ST_FILLWAIT: begin
        if (fillDone) begin
          strobes.retireSeg = 1'b1;
          nxt = ST_FILL;
        end
      end
      ST_WRITE: begin
        memReqValid = 1'b1;
        memReqKind  = MEM_WRITE;
        nxt = ST_WRWAIT;
      end
      ST_WRWAIT: begin
        if (memRspValid) nxt = ST_RESPOND;
      end
      ST_RESPOND: begin
        tlbFillValid = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  logic fillOut;
  always_ff @(posedge clk) begin
    if (!rstN)         fillOut <= 1'b0;
    else if (fillReq)  fillOut <= 1'b1;
    else if (fillDone) fillOut <= 1'b0;
  end

  assert_single_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> !fillOut);
  assert_no_alloc_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    allocReq |-> !pteNc);
endmodule

// File: rtl/footprintWalker.sv
module footprintWalker
  import walkerPkg::*;
#(
  parameter int SEGS    = 8,
  parameter int ADDR_W  = 20,
  parameter int VPN_W   = 8,
  parameter int BACKOFF = 4,
  localparam int SEG_IW = $clog2(SEGS),
  localparam int PTE_W  = 2 * SEGS + 3 + ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               walkReq,
  input  logic [VPN_W-1:0]   walkVpn,
  input  logic [SEG_IW-1:0]  walkSeg,
  output logic               walkReady,
  output logic               memReqValid,
  output logic [1:0]         memReqKind,
  output logic [VPN_W-1:0]   memReqAddr,
  output logic [PTE_W-1:0]   memReqData,
  input  logic               memRspValid,
  input  logic [PTE_W-1:0]   memRspData,
  output logic               allocReq,
  output logic [ADDR_W-1:0]  allocPhys,
  output logic [VPN_W-1:0]   allocVpn,
  input  logic               allocDone,
  input  logic [ADDR_W-1:0]  allocAddr,
  output logic               fillReq,
  output logic [ADDR_W-1:0]  fillAddr,
  output logic [SEG_IW-1:0]  fillSeg,
  input  logic               fillDone,
  output logic               tlbFillValid,
  output logic [VPN_W-1:0]   tlbFillVpn,
  output logic [ADDR_W-1:0]  tlbFillAddr,
  output logic [SEGS-1:0]    tlbFillValidVec,
  output logic [SEGS-1:0]    tlbFillRefVec,
  output logic               tlbFillBypass
);
  walkStrobes_t strobes;
  logic rspLocked, pteNc, validNz, demandHit, pendEmpty, backoffZero;
  logic memWrite;

  assign memWrite = memReqValid && (memReqKind == MEM_WRITE);

  walkerCtrl ctrl (
    .clk, .rstN, .walkReq, .memRspValid, .allocDone, .fillDone,
    .rspLocked, .pteNc, .validNz, .demandHit, .pendEmpty, .backoffZero,
    .strobes, .walkReady, .memReqValid, .memReqKind, .allocReq, .fillReq,
    .tlbFillValid
  );

  walkerData #(
    .SEGS(SEGS), .SEG_IW(SEG_IW), .ADDR_W(ADDR_W), .VPN_W(VPN_W),
    .PTE_W(PTE_W), .BACKOFF(BACKOFF)
  ) data (
    .clk, .rstN, .strobes, .walkVpn, .walkSeg, .memRspData, .allocAddr,
    .fillReqIn(fillReq), .tlbFillValidIn(tlbFillValid), .memWriteIn(memWrite),
    .rspLocked, .pteNc, .validNz, .demandHit, .pendEmpty, .backoffZero,
    .memReqAddr, .memReqData, .allocPhys, .allocVpn, .fillAddr, .fillSeg,
    .tlbFillVpn, .tlbFillAddr, .tlbFillValidVec, .tlbFillRefVec, .tlbFillBypass
  );
endmodule

// File: tb/footprintWalker_test.sv
module footprintWalker_test;
  localparam int SEGS = 8, ADDR_W = 20, VPN_W = 8, SEG_IW = 3;
  localparam int PTE_W = 2 * SEGS + 3 + ADDR_W;
  localparam int LKB = 2 * SEGS + 2;

  typedef struct {
    logic [VPN_W-1:0] vpn; logic [ADDR_W-1:0] addr;
    logic [SEGS-1:0] v; logic [SEGS-1:0] r; logic byp;
  } tlbItem_t;
  typedef struct { logic [ADDR_W-1:0] addr; logic [SEG_IW-1:0] seg; } fillItem_t;
  typedef struct { logic [VPN_W-1:0] vpn; logic [PTE_W-1:0] pte; } pteItem_t;

  logic clk = 0, rstN = 0;
  logic walkReq = 0; logic [VPN_W-1:0] walkVpn = '0; logic [SEG_IW-1:0] walkSeg = '0;
  logic walkReady, memReqValid; logic [1:0] memReqKind;
  logic [VPN_W-1:0] memReqAddr; logic [PTE_W-1:0] memReqData;
  logic memRspValid = 0; logic [PTE_W-1:0] memRspData = '0;
  logic allocReq; logic [ADDR_W-1:0] allocPhys; logic [VPN_W-1:0] allocVpn;
  logic allocDone = 0; logic [ADDR_W-1:0] allocAddr = '0;
  logic fillReq; logic [ADDR_W-1:0] fillAddr; logic [SEG_IW-1:0] fillSeg;
  logic fillDone = 0;
  logic tlbFillValid; logic [VPN_W-1:0] tlbFillVpn; logic [ADDR_W-1:0] tlbFillAddr;
  logic [SEGS-1:0] tlbFillValidVec, tlbFillRefVec; logic tlbFillBypass;

  always #10 clk = ~clk;

  footprintWalker uut (.*);

  // memory, allocator and fill-engine models
  logic [PTE_W-1:0] mem [256];
  logic preLoad = 0; logic [VPN_W-1:0] preVpn = '0; logic [PTE_W-1:0] preData = '0;
  int memDelay = 0, tasCount = 0, wrCount = 0, lockedUntil = 0, cyc = 0;
  logic [PTE_W-1:0] rspHold = '0; logic [VPN_W-1:0] lastWrVpn = '0;
  int allocDelay = 0, allocServed = 0, fillDelay = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (preLoad) mem[preVpn] <= preData;
    if (memDelay != 0) begin
      memDelay <= memDelay - 1;
      if (memDelay == 1) begin memRspValid <= 1'b1; memRspData <= rspHold; end
    end
    if (memReqValid) begin
      memDelay <= 2;
      if (memReqKind == 2'd1) begin
        if (tasCount < lockedUntil) rspHold <= mem[memReqAddr] | (PTE_W'(1) << LKB);
        else begin rspHold <= mem[memReqAddr]; mem[memReqAddr][LKB] <= 1'b1; end
        tasCount <= tasCount + 1;
      end else begin
        mem[memReqAddr] <= memReqData; rspHold <= '0;
        wrCount <= wrCount + 1; lastWrVpn <= memReqAddr;
      end
    end
  end

  always @(posedge clk) begin
    allocDone <= 1'b0;
    if (allocDelay != 0) begin
      allocDelay <= allocDelay - 1;
      if (allocDelay == 1) begin
        allocDone <= 1'b1; allocAddr <= 20'hA0000 + ADDR_W'(allocServed);
        allocServed <= allocServed + 1;
      end
    end
    if (allocReq) allocDelay <= 3;
  end

  always @(posedge clk) begin
    fillDone <= 1'b0;
    if (fillDelay != 0) begin
      fillDelay <= fillDelay - 1;
      if (fillDelay == 1) fillDone <= 1'b1;
    end
    if (fillReq) fillDelay <= 3;
  end

  // monitor
  tlbItem_t obsTlb[$]; fillItem_t obsFill[$];
  int allocSeen = 0, gapSeen = -1, lockRspCyc = 0;
  logic [ADDR_W-1:0] lastAllocPhys = '0; logic [VPN_W-1:0] lastAllocVpn = '0;
  logic [VPN_W-1:0] wrVpnAtTlb[$];
  bit gapArmed = 0;

  always @(negedge clk) begin
    if (tlbFillValid) begin
      obsTlb.push_back('{tlbFillVpn, tlbFillAddr, tlbFillValidVec, tlbFillRefVec, tlbFillBypass});
      wrVpnAtTlb.push_back(lastWrVpn);
    end
    if (fillReq) obsFill.push_back('{fillAddr, fillSeg});
    if (allocReq) begin allocSeen++; lastAllocPhys = allocPhys; lastAllocVpn = allocVpn; end
    if (memRspValid && memRspData[LKB]) begin lockRspCyc = cyc; gapArmed = 1; end
    if (memReqValid && gapArmed) begin gapSeen = cyc - lockRspCyc; gapArmed = 0; end
  end

  // scoreboard
  int total = 0, passed = 0, plannedAllocs = 0;
  tlbItem_t expTlb[$]; fillItem_t expFill[$]; pteItem_t expPte[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  function automatic logic [PTE_W-1:0] mkPte(logic [ADDR_W-1:0] a, bit lk, bit nc, bit c,
                                             logic [SEGS-1:0] r, logic [SEGS-1:0] v);
    return {a, lk, nc, c, r, v};
  endfunction

  task automatic prepare(logic [VPN_W-1:0] vpn, logic [SEG_IW-1:0] seg, logic [PTE_W-1:0] pte);
    logic [SEGS-1:0] v = pte[SEGS-1:0], r = pte[2*SEGS-1:SEGS], d = '0;
    logic [ADDR_W-1:0] a = pte[PTE_W-1:2*SEGS+3];
    bit nc = pte[2*SEGS+1], c = pte[2*SEGS];
    d[seg] = 1'b1;
    if (nc) begin
      expTlb.push_back('{vpn, a, '0, '0, 1'b1});
      expPte.push_back('{vpn, mkPte(a, 0, 1, c, r, v)});
    end else if (v != '0) begin
      if (!v[seg]) begin
        expFill.push_back('{a, seg});
        v = v | d; r = r | d;
      end
      expTlb.push_back('{vpn, a, v, r, 1'b0});
      expPte.push_back('{vpn, mkPte(a, 0, 0, c, r, v)});
    end else begin
      logic [ADDR_W-1:0] ca = 20'hA0000 + ADDR_W'(plannedAllocs);
      logic [SEGS-1:0] m = r | d;
      plannedAllocs++;
      for (int i = 0; i < SEGS; i++) if (m[i]) expFill.push_back('{ca, SEG_IW'(i)});
      expTlb.push_back('{vpn, ca, m, m, 1'b0});
      expPte.push_back('{vpn, mkPte(ca, 0, 0, 1, m, m)});
    end
    @(negedge clk); preLoad = 1; preVpn = vpn; preData = pte;
    @(negedge clk); preLoad = 0;
  endtask

  task automatic issue(logic [VPN_W-1:0] vpn, logic [SEG_IW-1:0] seg, output int waited);
    waited = 0;
    @(negedge clk); walkReq = 1; walkVpn = vpn; walkSeg = seg;
    while (!walkReady) begin waited++; @(negedge clk); end
    @(negedge clk); walkReq = 0;
  endtask

  task automatic drain(string tag);
    int wr0;
    while (obsTlb.size() < expTlb.size()) @(negedge clk);
    repeat (3) @(negedge clk);
    while (expTlb.size() != 0) begin
      tlbItem_t e = expTlb.pop_front(); tlbItem_t o = obsTlb.pop_front();
      logic [VPN_W-1:0] wv = wrVpnAtTlb.pop_front();
      check(o.addr == e.addr, tag, "tlb address", o.addr, e.addr);
      check(o.v == e.v && o.r == e.r, tag, "tlb valid/ref vectors", {o.v, o.r}, {e.v, e.r});
      check(o.byp == e.byp && o.vpn == e.vpn, tag, "tlb bypass/vpn", {o.byp, o.vpn}, {e.byp, e.vpn});
      check(wv == e.vpn, "R9", "entry write before tlb fill", wv, e.vpn);
    end
    check(obsFill.size() == expFill.size(), "R8", {tag, " transfer count"}, obsFill.size(), expFill.size());
    while (expFill.size() != 0 && obsFill.size() != 0) begin
      fillItem_t e = expFill.pop_front(); fillItem_t o = obsFill.pop_front();
      check(o.seg == e.seg && o.addr == e.addr, "R8", {tag, " transfer seg/addr"}, {o.addr, o.seg}, {e.addr, e.seg});
    end
    expFill.delete(); obsFill.delete();
    while (expPte.size() != 0) begin
      pteItem_t p = expPte.pop_front();
      check(mem[p.vpn] == p.pte, "R9", {tag, " entry write-back"}, mem[p.vpn], p.pte);
    end
    check(allocSeen == plannedAllocs, "R6", {tag, " allocation count"}, allocSeen, plannedAllocs);
    wr0 = wrCount;
  endtask

  task automatic runTests();
    int w, w2;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(walkReady == 1 && !memReqValid && !fillReq && !allocReq && !tlbFillValid,
          "R11", "reset outputs", {walkReady, memReqValid, fillReq, allocReq, tlbFillValid}, 5'b10000);
    rstN = 1;
    // R3 non-cacheable
    prepare(8'd3, 3'd2, mkPte(20'h12345, 0, 1, 0, 8'h0F, 8'h00));
    issue(8'd3, 3'd2, w); drain("R3");
    // R4 cached, demanded segment present
    prepare(8'd5, 3'd4, mkPte(20'h0BEEF, 0, 0, 1, 8'h10, 8'h30));
    issue(8'd5, 3'd4, w); drain("R4");
    // R5 cached, demanded segment missing
    prepare(8'd6, 3'd0, mkPte(20'h0CAFE, 0, 0, 1, 8'h10, 8'h30));
    issue(8'd6, 3'd0, w); drain("R5");
    // R6 / R7 allocation with reference mask
    prepare(8'd7, 3'd1, mkPte(20'h54321, 0, 0, 0, 8'hA4, 8'h00));
    issue(8'd7, 3'd1, w); drain("R7");
    check(lastAllocPhys == 20'h54321 && lastAllocVpn == 8'd7, "R6", "allocation phys/vpn",
          {lastAllocPhys, lastAllocVpn}, {20'h54321, 8'd7});
    // R7 zero reference vector: demanded segment only
    prepare(8'd8, 3'd6, mkPte(20'h11111, 0, 0, 0, 8'h00, 8'h00));
    issue(8'd8, 3'd6, w); drain("R7");
    // R2 / R1 lock held on first test-and-set
    prepare(8'd9, 3'd3, mkPte(20'h22222, 0, 0, 1, 8'h00, 8'h08));
    lockedUntil = tasCount + 1;
    issue(8'd9, 3'd3, w); drain("R1");
    check(gapSeen == 5, "R2", "retry gap after locked response", gapSeen, 5);
    // R10 back-to-back requests
    prepare(8'd10, 3'd7, mkPte(20'h44444, 0, 0, 0, 8'h81, 8'h00));
    prepare(8'd11, 3'd5, mkPte(20'h33333, 0, 0, 1, 8'h00, 8'h01));
    issue(8'd10, 3'd7, w);
    issue(8'd11, 3'd5, w2);
    check(w2 > 0, "R10", "second request held while busy", w2, 1);
    check(obsTlb.size() == 1, "R10", "first fill before second accepted", obsTlb.size(), 1);
    drain("R10");
  endtask

  initial begin
    bit finished = 0;
    fork
      begin runTests(); finished = 1; end
      begin repeat (20000) @(posedge clk); end
    join_any
    if (!finished) check(0, "WATCHDOG", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule